// File: doc/BRIEF.md
# USB Host Command and Status Register Unit

This block holds the run/stop control, the two schedule enables and the interrupt status of a high-speed USB host controller, all seen through a 32-bit register interface. The host bus writes the command word and the interrupt-enable mask, and it reads the status word or clears its event bits by writing ones. A schedule engine outside the block reports events: the asynchronous schedule has advanced, the asynchronous schedule is empty, a host system error, a frame list rollover, a port change, a completed transfer and a failed transfer. It also raises ready signals that show when a schedule or the whole engine has really reached the state it was asked for.

The status flags for the schedules and for the halted state do not copy the command bits directly. Each one moves only after a fixed settling window has passed and the engine's ready signal confirms the change. A host system error turns run/stop off in hardware. A doorbell bit in the command word arms a single async-advance status event.

Top module: `hc_cmd_stat`

## Requirements
- R1: After reset the status word (offset 0x24) reads 0x0000_1000, the command word (offset 0x20) and the interrupt-enable word (offset 0x28) read 0, and `irq` is 0.
- R2: Status bits 31:16 and 11:6 always read 0. Status bits 15:12 ignore writes. Status bit 13 shows the `asyncEmpty` input without delay. Command bits other than 0 (run), 4 (periodic enable), 5 (async enable) and 6 (doorbell) read 0. Any other offset reads 0.
- R3: Status bit 12 (halted) clears on the clock edge that writes run=1. After run falls, halted sets on the 4th rising edge if `engineIdle` is high there. Otherwise it sets on the first later edge where `engineIdle` is high.
- R4: Status bit 15 follows command bit 5 and status bit 14 follows command bit 4. A change takes effect on the 4th rising edge after the enable bit changes, or on the first later edge where the matching ready input is high.
- R5: A `hostErr` pulse sets status bit 5 and clears run. The clear wins over a command write of run=1 in the same cycle. Halted then follows R3.
- R6: A command write with bit 6 set arms the doorbell only if status bit 15 is 1. While armed, an `asyncAdvance` pulse sets status bit 4 and clears command bit 6 on the same edge. When status bit 15 is 0 the doorbell write has no effect.
- R7: `frameRoll`, `portChg`, `xferErr` and `xferDone` set status bits 3, 2, 1 and 0. Status bits 5:0 clear when 1 is written to them and keep their value when 0 is written. An event in the same cycle as a clear of its bit leaves the bit set.
- R8: `irq` is high exactly when some status bit among 5:0 is set and the same bit of the interrupt-enable word (offset 0x28, bits 5:0) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Register byte offset for reads and writes |
| regWr | input | 1 | Write strobe, one word per cycle |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr`, combinational |
| schedAsyncReady | input | 1 | Engine confirms the async schedule can change state |
| schedPeriodicReady | input | 1 | Engine confirms the periodic schedule can change state |
| engineIdle | input | 1 | Engine has stopped all execution |
| asyncAdvance | input | 1 | Async schedule advanced (pulse) |
| asyncEmpty | input | 1 | Async schedule found empty |
| hostErr | input | 1 | Host system error (pulse) |
| frameRoll | input | 1 | Frame list rollover (pulse) |
| portChg | input | 1 | Port change detected (pulse) |
| xferErr | input | 1 | Transfer finished with error (pulse) |
| xferDone | input | 1 | Transfer completed (pulse) |
| irq | output | 1 | Interrupt request |

## Verification
A stuck settling counter shows at the ports as a schedule or halted status bit that stays at its old value past the 4th edge after a command change. A counter that runs early shows as a bit that flips before that edge, so the bench samples after every edge of the window. A doorbell latch in the wrong state shows on the next read of command bit 6, or as a missing or spurious status bit 4 right after the next `asyncAdvance`. A wrong event or mask bit shows on `irq` in the same cycle, and the full sweep of event patterns against every mask exposes it.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
  localparam int RUN_BIT  = 0;
  localparam int PSE_BIT  = 4;
  localparam int ASE_BIT  = 5;
  localparam int DOOR_BIT = 6;

  localparam int ST_ASYNC  = 15;
  localparam int ST_PERIOD = 14;
  localparam int ST_RECL   = 13;
  localparam int ST_HALT   = 12;
  localparam int NUM_EVT   = 6;
  localparam int NUM_TRACK = 3;  // 0 async, 1 periodic, 2 halted

  typedef struct packed {
    logic cmdWr;
    logic stsWr;
    logic ieWr;
    logic rdCmd;
    logic rdSts;
    logic rdIe;
    logic asyncOn;
    logic periodicOn;
    logic halted;
  } ctrlStrobes_t;
endpackage

// File: rtl/hcr_settle.sv
module hcr_settle #(
  parameter int   SETTLE    = 4,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic target,
  input  logic ready,
  input  logic fastClr,
  output logic state
);
  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

  logic [CW-1:0] waitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= RESET_VAL;
      waitCnt <= '0;
    end else if (fastClr) begin
      state   <= 1'b0;
      waitCnt <= '0;
    end else if (state == target) begin
      waitCnt <= '0;
    end else if (waitCnt == LAST) begin
      if (ready) begin
        state   <= target;
        waitCnt <= '0;
      end
    end else begin
      waitCnt <= waitCnt + 1'b1;
    end
  end
endmodule

// File: rtl/hcr_ctrl.sv
module hcr_ctrl
  import hcr_pkg::*;
#(
  parameter int             ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] CMD_OFS = 8'h20,
  parameter logic [ADDR_W-1:0] STS_OFS = 8'h24,
  parameter logic [ADDR_W-1:0] IE_OFS  = 8'h28,
  parameter int             SETTLE  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              asEnQ,
  input  logic              psEnQ,
  input  logic              runQ,
  input  logic              runNext,
  input  logic              schedAsyncReady,
  input  logic              schedPeriodicReady,
  input  logic              engineIdle,
  output ctrlStrobes_t      strb
);
  logic [NUM_TRACK-1:0] trkTarget;
  logic [NUM_TRACK-1:0] trkReady;
  logic [NUM_TRACK-1:0] trkFast;
  logic [NUM_TRACK-1:0] trkState;

  assign trkTarget = {~runQ, psEnQ, asEnQ};
  assign trkReady  = {engineIdle, schedPeriodicReady, schedAsyncReady};
  assign trkFast   = {runNext, 1'b0, 1'b0};

  for (genvar g = 0; g < NUM_TRACK; g++) begin : g_track
    localparam logic RV = (g == 2) ? 1'b1 : 1'b0;
    hcr_settle #(.SETTLE(SETTLE), .RESET_VAL(RV)) u_settle (
      .clk    (clk),
      .rstN   (rstN),
      .target (trkTarget[g]),
      .ready  (trkReady[g]),
      .fastClr(trkFast[g]),
      .state  (trkState[g])
    );
  end

  always_comb begin
    strb.rdCmd      = (regAddr == CMD_OFS);
    strb.rdSts      = (regAddr == STS_OFS);
    strb.rdIe       = (regAddr == IE_OFS);
    strb.cmdWr      = regWr && strb.rdCmd;
    strb.stsWr      = regWr && strb.rdSts;
    strb.ieWr       = regWr && strb.rdIe;
    strb.asyncOn    = trkState[0];
    strb.periodicOn = trkState[1];
    strb.halted     = trkState[2];
  end
endmodule

// File: rtl/hcr_data.sv
module hcr_data
  import hcr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strb,
  input  logic [31:0]        regWdata,
  input  logic               asyncAdvance,
  input  logic               asyncEmpty,
  input  logic               hostErr,
  input  logic               frameRoll,
  input  logic               portChg,
  input  logic               xferErr,
  input  logic               xferDone,
  output logic [31:0]        regRdata,
  output logic               irq,
  output logic               runQ,
  output logic               runNext,
  output logic               asEnQ,
  output logic               psEnQ,
  output logic               doorQ,
  output logic [NUM_EVT-1:0] evtQ
);
  logic [NUM_EVT-1:0] ieQ;
  logic [NUM_EVT-1:0] evtSet;
  logic [NUM_EVT-1:0] evtClr;
  logic               doorFire;
  logic [31:0]        cmdView;
  logic [31:0]        stsView;

  assign doorFire = doorQ && asyncAdvance;

  always_comb begin
    if (hostErr)         runNext = 1'b0;
    else if (strb.cmdWr) runNext = regWdata[RUN_BIT];
    else                 runNext = runQ;
  end

  assign evtSet = {hostErr, doorFire, frameRoll, portChg, xferErr, xferDone};
  assign evtClr = strb.stsWr ? regWdata[NUM_EVT-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ  <= 1'b0;
      asEnQ <= 1'b0;
      psEnQ <= 1'b0;
      doorQ <= 1'b0;
      evtQ  <= '0;
      ieQ   <= '0;
    end else begin
      runQ <= runNext;
      if (strb.cmdWr) begin
        asEnQ <= regWdata[ASE_BIT];
        psEnQ <= regWdata[PSE_BIT];
      end
      if (doorFire) doorQ <= 1'b0;
      else if (strb.cmdWr && regWdata[DOOR_BIT] && strb.asyncOn) doorQ <= 1'b1;
      evtQ <= (evtQ & ~evtClr) | evtSet;
      if (strb.ieWr) ieQ <= regWdata[NUM_EVT-1:0];
    end
  end

  always_comb begin
    cmdView           = '0;
    cmdView[RUN_BIT]  = runQ;
    cmdView[PSE_BIT]  = psEnQ;
    cmdView[ASE_BIT]  = asEnQ;
    cmdView[DOOR_BIT] = doorQ;
    stsView            = '0;
    stsView[ST_ASYNC]  = strb.asyncOn;
    stsView[ST_PERIOD] = strb.periodicOn;
    stsView[ST_RECL]   = asyncEmpty;
    stsView[ST_HALT]   = strb.halted;
    stsView[NUM_EVT-1:0] = evtQ;
    if (strb.rdCmd)      regRdata = cmdView;
    else if (strb.rdSts) regRdata = stsView;
    else if (strb.rdIe)  regRdata = {{(32-NUM_EVT){1'b0}}, ieQ};
    else                 regRdata = '0;
  end

  assign irq = |(evtQ & ieQ);
endmodule

// File: rtl/hc_cmd_stat.sv
module hc_cmd_stat
  import hcr_pkg::*;
#(
  parameter int                ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] CMD_OFS = 8'h20,
  parameter logic [ADDR_W-1:0] STS_OFS = 8'h24,
  parameter logic [ADDR_W-1:0] IE_OFS  = 8'h28,
  parameter int                SETTLE  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              schedAsyncReady,
  input  logic              schedPeriodicReady,
  input  logic              engineIdle,
  input  logic              asyncAdvance,
  input  logic              asyncEmpty,
  input  logic              hostErr,
  input  logic              frameRoll,
  input  logic              portChg,
  input  logic              xferErr,
  input  logic              xferDone,
  output logic              irq
);
  ctrlStrobes_t       strb;
  logic               runQ;
  logic               runNext;
  logic               asEnQ;
  logic               psEnQ;
  logic               doorQ;
  logic [NUM_EVT-1:0] evtQ;

  hcr_ctrl #(
    .ADDR_W(ADDR_W), .CMD_OFS(CMD_OFS), .STS_OFS(STS_OFS),
    .IE_OFS(IE_OFS), .SETTLE(SETTLE)
  ) u_ctrl (
    .clk               (clk),
    .rstN              (rstN),
    .regAddr           (regAddr),
    .regWr             (regWr),
    .asEnQ             (asEnQ),
    .psEnQ             (psEnQ),
    .runQ              (runQ),
    .runNext           (runNext),
    .schedAsyncReady   (schedAsyncReady),
    .schedPeriodicReady(schedPeriodicReady),
    .engineIdle        (engineIdle),
    .strb              (strb)
  );

  hcr_data u_data (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .regWdata    (regWdata),
    .asyncAdvance(asyncAdvance),
    .asyncEmpty  (asyncEmpty),
    .hostErr     (hostErr),
    .frameRoll   (frameRoll),
    .portChg     (portChg),
    .xferErr     (xferErr),
    .xferDone    (xferDone),
    .regRdata    (regRdata),
    .irq         (irq),
    .runQ        (runQ),
    .runNext     (runNext),
    .asEnQ       (asEnQ),
    .psEnQ       (psEnQ),
    .doorQ       (doorQ),
    .evtQ        (evtQ)
  );
endmodule

// File: rtl/hcr_checker.sv
module hcr_checker #(
  parameter int                ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] STS_OFS = 8'h24
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWr,
  input logic [31:0]       regWdata,
  input logic              hostErr,
  input logic              asyncAdvance,
  input logic              xferDone,
  input logic              irq,
  input logic              runQ,
  input logic              haltedQ,
  input logic              doorQ,
  input logic              asyncOn,
  input logic              asEnQ,
  input logic [5:0]        evtQ
);
  p_run_not_halted_r3: assert property (@(posedge clk) disable iff (!rstN)
    runQ |-> !haltedQ);

  p_err_stops_r5: assert property (@(posedge clk) disable iff (!rstN)
    hostErr |=> (!runQ && evtQ[5]));

  p_door_fire_r6: assert property (@(posedge clk) disable iff (!rstN)
    (doorQ && asyncAdvance) |=> (!doorQ && evtQ[4]));

  p_door_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!doorQ && !asyncOn) |=> !doorQ);

  p_async_track_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(asyncOn) |-> (asyncOn == $past(asEnQ)));

  p_w1c_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == STS_OFS && regWdata[0] && !xferDone) |=> !evtQ[0]);

  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (evtQ != 6'd0));
endmodule

bind hc_cmd_stat hcr_checker #(.ADDR_W(ADDR_W), .STS_OFS(STS_OFS)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .regAddr     (regAddr),
  .regWr       (regWr),
  .regWdata    (regWdata),
  .hostErr     (hostErr),
  .asyncAdvance(asyncAdvance),
  .xferDone    (xferDone),
  .irq         (irq),
  .runQ        (runQ),
  .haltedQ     (strb.halted),
  .doorQ       (doorQ),
  .asyncOn     (strb.asyncOn),
  .asEnQ       (asEnQ),
  .evtQ        (evtQ)
);

// File: tb/hc_cmd_stat_tb_top.sv
module hc_cmd_stat_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CMD = 8'h20;
  localparam logic [7:0] A_STS = 8'h24;
  localparam logic [7:0] A_IE  = 8'h28;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWr = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic schedAsyncReady = 1'b1, schedPeriodicReady = 1'b1, engineIdle = 1'b1;
  logic asyncAdvance = 1'b0, asyncEmpty = 1'b0, hostErr = 1'b0;
  logic frameRoll = 1'b0, portChg = 1'b0, xferErr = 1'b0, xferDone = 1'b0;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hc_cmd_stat dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata),
    .schedAsyncReady(schedAsyncReady), .schedPeriodicReady(schedPeriodicReady),
    .engineIdle(engineIdle), .asyncAdvance(asyncAdvance), .asyncEmpty(asyncEmpty),
    .hostErr(hostErr), .frameRoll(frameRoll), .portChg(portChg),
    .xferErr(xferErr), .xferDone(xferDone), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    regAddr = a;
    #1;
    v = regRdata;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [5:0]  stsExp;
    tick(3);
    rstN = 1'b1;

    // R1 reset state
    rd(A_STS, v); chk("R1 status reset", v, 32'h0000_1000);
    rd(A_CMD, v); chk("R1 command reset", v, 32'h0);
    rd(A_IE, v);  chk("R1 enable reset", v, 32'h0);
    chk("R1 irq reset", {31'b0, irq}, 32'h0);

    // R2 unmapped offset, reclamation mirror
    rd(8'h30, v); chk("R2 unmapped read", v, 32'h0);
    asyncEmpty = 1'b1;
    rd(A_STS, v); chk("R2 reclamation mirror", v, 32'h0000_3000);
    asyncEmpty = 1'b0;

    // R3 halted clears with run, sets on 4th edge after stop
    wr(A_CMD, 32'h1);
    rd(A_CMD, v); chk("R3 run set", v, 32'h1);
    rd(A_STS, v); chk("R3 halted cleared", {31'b0, v[12]}, 32'h0);
    wr(A_CMD, 32'h0);
    rd(A_STS, v); chk("R3 halted edge0", {31'b0, v[12]}, 32'h0);
    for (int k = 1; k <= 3; k++) begin
      tick(1); rd(A_STS, v); chk("R3 halted early", {31'b0, v[12]}, 32'h0);
    end
    tick(1); rd(A_STS, v); chk("R3 halted edge4", {31'b0, v[12]}, 32'h1);
    wr(A_CMD, 32'h1);
    engineIdle = 1'b0;
    wr(A_CMD, 32'h0);
    tick(6); rd(A_STS, v); chk("R3 halted waits idle", {31'b0, v[12]}, 32'h0);
    engineIdle = 1'b1;
    tick(1); rd(A_STS, v); chk("R3 halted after idle", {31'b0, v[12]}, 32'h1);

    // R4 async status window
    wr(A_CMD, 32'h20);
    rd(A_STS, v); chk("R4 async edge0", {31'b0, v[15]}, 32'h0);
    for (int k = 1; k <= 3; k++) begin
      tick(1); rd(A_STS, v); chk("R4 async early", {31'b0, v[15]}, 32'h0);
    end
    tick(1); rd(A_STS, v); chk("R4 async edge4", {31'b0, v[15]}, 32'h1);
    // R4 periodic with ready held low
    schedPeriodicReady = 1'b0;
    wr(A_CMD, 32'h30);
    tick(8); rd(A_STS, v); chk("R4 periodic waits ready", {31'b0, v[14]}, 32'h0);
    schedPeriodicReady = 1'b1;
    tick(1); rd(A_STS, v); chk("R4 periodic after ready", {31'b0, v[14]}, 32'h1);

    // R6 doorbell armed and fired
    wr(A_CMD, 32'h70);
    rd(A_CMD, v); chk("R6 doorbell armed", v, 32'h70);
    @(negedge clk); asyncAdvance = 1'b1;
    @(negedge clk); asyncAdvance = 1'b0;
    rd(A_CMD, v); chk("R6 doorbell self clear", v, 32'h30);
    rd(A_STS, v); chk("R6 advance status", {26'b0, v[5:0]}, 32'h10);
    wr(A_STS, 32'h10);
    rd(A_STS, v); chk("R7 clear bit4", {26'b0, v[5:0]}, 32'h0);
    // R6 doorbell ignored while async status is 0
    wr(A_CMD, 32'h10);
    tick(5); rd(A_STS, v); chk("R4 async off", {31'b0, v[15]}, 32'h0);
    wr(A_CMD, 32'h50);
    rd(A_CMD, v); chk("R6 doorbell ignored", v, 32'h10);
    @(negedge clk); asyncAdvance = 1'b1;
    @(negedge clk); asyncAdvance = 1'b0;
    rd(A_STS, v); chk("R6 no advance status", {26'b0, v[5:0]}, 32'h0);

    // R5 host system error
    wr(A_CMD, 32'h11);
    @(negedge clk); hostErr = 1'b1;
    @(negedge clk); hostErr = 1'b0;
    rd(A_CMD, v); chk("R5 run cleared", v, 32'h10);
    rd(A_STS, v); chk("R5 error status", {26'b0, v[5:0]}, 32'h20);
    tick(4); rd(A_STS, v); chk("R5 halted follows", {31'b0, v[12]}, 32'h1);
    @(negedge clk);
    regAddr = A_CMD; regWdata = 32'h11; regWr = 1'b1; hostErr = 1'b1;
    @(negedge clk);
    regWr = 1'b0; hostErr = 1'b0;
    rd(A_CMD, v); chk("R5 error beats run write", v, 32'h10);
    wr(A_STS, 32'h3F);

    // R7 events, write-zero keeps, set beats clear
    @(negedge clk); frameRoll = 1'b1; portChg = 1'b1;
    @(negedge clk); frameRoll = 1'b0; portChg = 1'b0;
    @(negedge clk); xferErr = 1'b1; xferDone = 1'b1;
    @(negedge clk); xferErr = 1'b0; xferDone = 1'b0;
    rd(A_STS, v); chk("R7 event bits", {26'b0, v[5:0]}, 32'h0F);
    wr(A_STS, 32'h0);
    rd(A_STS, v); chk("R7 write zero keeps", {26'b0, v[5:0]}, 32'h0F);
    wr(A_STS, 32'h0A);
    rd(A_STS, v); chk("R7 partial clear", {26'b0, v[5:0]}, 32'h05);
    @(negedge clk);
    regAddr = A_STS; regWdata = 32'h01; regWr = 1'b1; xferDone = 1'b1;
    @(negedge clk);
    regWr = 1'b0; xferDone = 1'b0;
    rd(A_STS, v); chk("R7 set beats clear", {26'b0, v[5:0]}, 32'h05);

    // R8 sweep of event patterns against every mask
    for (int p = 0; p < 32; p++) begin
      wr(A_STS, 32'h3F);
      @(negedge clk);
      hostErr = p[4]; frameRoll = p[3]; portChg = p[2]; xferErr = p[1]; xferDone = p[0];
      @(negedge clk);
      hostErr = 1'b0; frameRoll = 1'b0; portChg = 1'b0; xferErr = 1'b0; xferDone = 1'b0;
      stsExp = {p[4], 1'b0, p[3], p[2], p[1], p[0]};
      rd(A_STS, v); chk("R8 sweep status", {26'b0, v[5:0]}, {26'b0, stsExp});
      for (int m = 0; m < 64; m++) begin
        wr(A_IE, 32'(m));
        chk("R8 irq", {31'b0, irq}, {31'b0, |(stsExp & 6'(m))});
      end
    end
    wr(A_IE, 32'h0);

    // R2 writes ignored on status bits 15:12 and reserved bits
    wr(A_STS, 32'hFFFF_FFFF);
    rd(A_STS, v); chk("R2 status write ignored", v, 32'h0000_5000);
    wr(A_CMD, 32'hFFFF_FF8E);
    rd(A_CMD, v); chk("R2 command reserved", v, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule